// File: doc/BRIEF.md
# Timestamped Sample Packet Framer

The framer sits between a decimating receive filter and a 16-bit packet FIFO that a host link drains. Every sample strobe from the filter carries one I/Q pair. The framer turns the stream into fixed-size packets. Each packet has two header words, then two words of sample time, then the payload. The sample time comes from a 32-bit counter inside the block that advances on every strobe. The counter is latched at the first sample of each packet, not when the packet opens. As a result the headers go out before that sample exists, and the timestamp names the real time of the first payload sample.

A run starts on the rising edge of `enable`. It starts at once, or it waits until the sample-time counter reaches a programmed value. It then produces packets back to back. In count mode it stops after a programmed number of packets and pulses `done`. In continuous mode it keeps going until `enable` falls, then closes the packet in progress. Samples go out as two words (I then Q) in wide mode, or as one packed word in narrow mode. If the FIFO is full when a sample arrives or a word is due, the block drops the data, raises a sticky overrun flag and restarts with a fresh packet.

Configuration inputs (`count_mode`, `pkt_total`, `timed_start`, `start_time`, `narrow`, `pkt_samples`) must stay stable while a run is active. `pkt_total` and `pkt_samples` must be at least 1. Strobes must be at least 8 clocks apart in wide mode and at least 4 clocks apart in narrow mode.

Top module: `pkt_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, `fifo_wr`, `done` and `overrun` are all 0, and the sample-time counter is 0.
- R2: Each packet is written as header-high, header-low, timestamp-high, timestamp-low, then its payload words. No word is written outside this order, and nothing is written while the block is idle.
- R3: Header-high holds the sticky overrun flag in bit 15 and a sequence number in bits 14:0. The sequence number is 0 for the first header after a run is armed and rises by one for each header written. Header-low holds the payload length in words: `pkt_samples` in narrow mode, 2·`pkt_samples` in wide mode.
- R4: The sample-time counter starts at 0 and adds one on every strobe, including strobes that are ignored or dropped. A packet's timestamp is the counter value seen with its first sample, high 16 bits first.
- R5: Both header words are written as soon as a packet opens, without waiting for a sample. Timestamp words appear only after the packet's first strobe.
- R6: In wide mode (`narrow`=0) each sample is written as two words, `smp_i` first and then `smp_q`.
- R7: In narrow mode (`narrow`=1) each sample is written as one word, with `smp_i[15:8]` in bits 15:8 and `smp_q[15:8]` in bits 7:0.
- R8: Every packet carries exactly `pkt_samples` samples. The next packet's header follows the last payload word of the previous packet without waiting for a sample.
- R9: With `count_mode`=1 the run ends after `pkt_total` complete packets. `done` is high for one cycle, together with the write of the last word, and no further words are written until the next arm.
- R10: With `count_mode`=0 packets continue while `enable` stays high. After `enable` falls, the packet in progress is completed and no new packet starts. `done` is never raised in this mode.
- R11: With `timed_start`=1 no word is written until the counter equals `start_time`. The first packet's timestamp is then equal to `start_time`.
- R12: A strobe or a due word that meets `fifo_full`=1 causes no write and sets `overrun`. The current packet is abandoned, and a new packet begins with a fresh header and a fresh timestamp. Abandoned packets do not count toward `pkt_total`. `overrun` stays set until the next arm and is cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Rising edge arms a run; low stops it |
| count_mode | input | 1 | 1: stop after `pkt_total` packets; 0: continuous |
| pkt_total | input | 16 | Number of packets in count mode |
| timed_start | input | 1 | 1: wait for the counter to reach `start_time` |
| start_time | input | 32 | Sample time at which a timed run begins |
| narrow | input | 1 | 1: one packed word per sample; 0: I and Q words |
| pkt_samples | input | 12 | Samples per packet |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 16 | In-phase sample |
| smp_q | input | 16 | Quadrature sample |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | 16 | Word written to the FIFO |
| overrun | output | 1 | Sticky overrun flag |
| done | output | 1 | One-cycle pulse at the last word of a counted run |

## Verification
The bench goes after the timestamp taken at the first sample rather than at packet start. A design that latched time when the headers went out would show a counter value one or more strobes too early. Timed starts are checked against `start_time` exactly, so a design that begins before the counter reaches `start_time` writes a packet the bench did not expect. An overrun is forced at a strobe in the middle of a packet. A design that kept filling the old packet, or reused its timestamp, would miscompare on the restarted header's flag, its sequence number or its time. The tests that drop `enable` and end counted runs look for stray words after the stop, and for a missing or repeated `done` pulse.

// File: rtl/pkt_framer_pkg.sv
`timescale 1ns/1ps
package pkt_framer_pkg;

    // word-writer sequencing
    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,
        W_HDRH  = 3'd1,
        W_HDRL  = 3'd2,
        W_WAITF = 3'd3,
        W_TSL   = 3'd4,
        W_SMPA  = 3'd5,
        W_SMPB  = 3'd6,
        W_WAITS = 3'd7
    } wr_state_e;

    // run control
    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_WAIT = 2'd1,
        R_RUN  = 2'd2,
        R_HALT = 2'd3
    } run_state_e;

endpackage

// File: rtl/pf_ts_counter.sv
`timescale 1ns/1ps
module pf_ts_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] count
);
    logic [TS_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (tick) count_d = count_q + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/pf_run_ctrl.sv
`timescale 1ns/1ps
module pf_run_ctrl
    import pkt_framer_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            timed_start,
    input  logic [TS_W-1:0] start_time,
    input  logic [TS_W-1:0] ts,
    input  logic            finish,
    output logic            run,
    output logic            arm
);
    typedef struct packed {
        run_state_e st;
        logic       en;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  arm_c;

    always_comb begin
        r_d    = r_q;
        r_d.en = enable;
        arm_c  = 1'b0;
        case (r_q.st)
            R_IDLE: begin
                if (enable && !r_q.en) begin
                    arm_c  = 1'b1;
                    r_d.st = timed_start ? R_WAIT : R_RUN;
                end
            end
            R_WAIT: begin
                if (!enable)               r_d.st = R_IDLE;
                else if (ts == start_time) r_d.st = R_RUN;
            end
            R_RUN: begin
                if (!enable)     r_d.st = R_IDLE;
                else if (finish) r_d.st = R_HALT;
            end
            R_HALT: begin
                if (!enable) r_d.st = R_IDLE;
            end
            default: r_d.st = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run = (r_q.st == R_RUN);
    assign arm = arm_c;
endmodule

// File: rtl/pf_writer.sv
`timescale 1ns/1ps
module pf_writer
    import pkt_framer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SAMP_W = 12,
    parameter int CNT_W  = 16,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              arm,
    input  logic              count_mode,
    input  logic [CNT_W-1:0]  pkt_total,
    input  logic              narrow,
    input  logic [SAMP_W-1:0] pkt_samples,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    input  logic [TS_W-1:0]   ts,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              overrun,
    output logic              finish
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SEQ_W  = DATA_W - 1;

    typedef struct packed {
        wr_state_e         st;
        logic              pend;
        logic [DATA_W-1:0] hold_i;
        logic [DATA_W-1:0] hold_q;
        logic [TS_W-1:0]   hold_ts;
        logic [SAMP_W-1:0] smp_cnt;
        logic [CNT_W-1:0]  pkt_cnt;
        logic [SEQ_W-1:0]  seq;
        logic              ovf;
    } wr_t;

    wr_t               w_d, w_q;
    logic              wr_due;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] first_word;
    logic [DATA_W-1:0] len_words;
    logic              active;
    logic              stall;
    logic              last_word;
    logic              fin_c;

    always_comb begin
        first_word = narrow ? {w_q.hold_i[DATA_W-1 -: HALF_W], w_q.hold_q[DATA_W-1 -: HALF_W]}
                            : w_q.hold_i;
        len_words  = narrow ? DATA_W'(pkt_samples) : DATA_W'({pkt_samples, 1'b0});
        active     = (w_q.st != W_IDLE);

        // word selection for the current state
        wr_due = 1'b0;
        word   = '0;
        case (w_q.st)
            W_HDRH:  begin wr_due = 1'b1; word = {w_q.ovf, w_q.seq}; end
            W_HDRL:  begin wr_due = 1'b1; word = len_words; end
            W_WAITF: begin wr_due = w_q.pend; word = w_q.hold_ts[TS_W-1 -: DATA_W]; end
            W_TSL:   begin wr_due = 1'b1; word = w_q.hold_ts[DATA_W-1:0]; end
            W_SMPA:  begin wr_due = 1'b1; word = first_word; end
            W_WAITS: begin wr_due = w_q.pend; word = first_word; end
            W_SMPB:  begin wr_due = 1'b1; word = w_q.hold_q; end
            default: begin wr_due = 1'b0; word = '0; end
        endcase

        stall = active && fifo_full && (wr_due || smp_valid);

        w_d       = w_q;
        last_word = 1'b0;
        fin_c     = 1'b0;

        if (arm) begin
            w_d.seq     = '0;
            w_d.pkt_cnt = '0;
            w_d.ovf     = 1'b0;
        end

        if (stall) begin
            // drop, flag, and reopen a fresh packet
            w_d.ovf     = 1'b1;
            w_d.st      = W_HDRH;
            w_d.pend    = 1'b0;
            w_d.smp_cnt = '0;
        end else begin
            case (w_q.st)
                W_IDLE: begin
                    if (run) begin
                        w_d.st      = W_HDRH;
                        w_d.smp_cnt = '0;
                    end
                end
                W_HDRH: begin
                    w_d.seq = w_q.seq + SEQ_W'(1);
                    w_d.st  = W_HDRL;
                end
                W_HDRL: w_d.st = W_WAITF;
                W_WAITF: begin
                    if (w_q.pend) begin
                        w_d.pend = 1'b0;
                        w_d.st   = W_TSL;
                    end
                end
                W_TSL: w_d.st = W_SMPA;
                W_SMPA: begin
                    if (narrow) last_word = 1'b1;
                    else        w_d.st    = W_SMPB;
                end
                W_WAITS: begin
                    if (w_q.pend) begin
                        w_d.pend = 1'b0;
                        if (narrow) last_word = 1'b1;
                        else        w_d.st    = W_SMPB;
                    end
                end
                W_SMPB: last_word = 1'b1;
                default: w_d.st = W_IDLE;
            endcase

            if (last_word) begin
                if (w_q.smp_cnt == pkt_samples - SAMP_W'(1)) begin
                    w_d.smp_cnt = '0;
                    w_d.pkt_cnt = w_q.pkt_cnt + CNT_W'(1);
                    if (count_mode && (w_q.pkt_cnt + CNT_W'(1) == pkt_total)) begin
                        fin_c  = 1'b1;
                        w_d.st = W_IDLE;
                    end else if (run) begin
                        w_d.st = W_HDRH;
                    end else begin
                        w_d.st = W_IDLE;
                    end
                end else begin
                    w_d.smp_cnt = w_q.smp_cnt + SAMP_W'(1);
                    w_d.st      = W_WAITS;
                end
            end
        end

        // capture an accepted strobe with the time it arrived
        if (active && smp_valid && !fifo_full) begin
            w_d.pend    = 1'b1;
            w_d.hold_i  = smp_i;
            w_d.hold_q  = smp_q;
            w_d.hold_ts = ts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign fifo_wr   = wr_due && !fifo_full;
    assign fifo_data = word;
    assign overrun   = w_q.ovf;
    assign finish    = fin_c;
endmodule

// File: rtl/pkt_framer.sv
`timescale 1ns/1ps
module pkt_framer #(
    parameter int DATA_W = 16,
    parameter int SAMP_W = 12,
    parameter int CNT_W  = 16,
    parameter int TS_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              count_mode,
    input  logic [CNT_W-1:0]  pkt_total,
    input  logic              timed_start,
    input  logic [TS_W-1:0]   start_time,
    input  logic              narrow,
    input  logic [SAMP_W-1:0] pkt_samples,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              overrun,
    output logic              done
);
    logic [TS_W-1:0] ts_now;
    logic            run;
    logic            arm;
    logic            finish;

    pf_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_valid),
        .count (ts_now)
    );

    pf_run_ctrl #(.TS_W(TS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .timed_start (timed_start),
        .start_time  (start_time),
        .ts          (ts_now),
        .finish      (finish),
        .run         (run),
        .arm         (arm)
    );

    pf_writer #(
        .DATA_W (DATA_W),
        .SAMP_W (SAMP_W),
        .CNT_W  (CNT_W),
        .TS_W   (TS_W)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .arm         (arm),
        .count_mode  (count_mode),
        .pkt_total   (pkt_total),
        .narrow      (narrow),
        .pkt_samples (pkt_samples),
        .smp_valid   (smp_valid),
        .smp_i       (smp_i),
        .smp_q       (smp_q),
        .ts          (ts_now),
        .fifo_full   (fifo_full),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data),
        .overrun     (overrun),
        .finish      (finish)
    );

    assign done = finish;
endmodule

// File: rtl/pkt_framer_chk.sv
`timescale 1ns/1ps
module pkt_framer_chk #(
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            smp_valid,
    input logic            fifo_full,
    input logic            fifo_wr,
    input logic            done,
    input logic            overrun,
    input logic [TS_W-1:0] ts
);
    // R1: quiet outputs on the first cycle out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!fifo_wr && !done && !overrun && ts == '0));

    // R4: counter advances by one per strobe
    p_ts_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (ts == $past(ts) + TS_W'(1)));

    // R4: counter holds without a strobe
    p_ts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(ts));

    // R9: done lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done coincides with an actual write
    p_done_with_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fifo_wr);

    // R12: overrun only rises after the FIFO reported full
    p_overrun_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(fifo_full));

    // R12: overrun only clears on an arm (enable rising)
    p_overrun_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> ($past(enable) && !$past(enable, 2)));
endmodule

bind pkt_framer pkt_framer_chk #(.TS_W(TS_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .smp_valid (smp_valid),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .done      (done),
    .overrun   (overrun),
    .ts        (ts_now)
);

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        count_mode;
    logic [15:0] pkt_total;
    logic        timed_start;
    logic [31:0] start_time;
    logic        narrow;
    logic [11:0] pkt_samples;
    logic        smp_valid;
    logic [15:0] smp_i;
    logic [15:0] smp_q;
    logic        fifo_full;
    logic        fifo_wr;
    logic [15:0] fifo_data;
    logic        overrun;
    logic        done;

    always #2 clk = ~clk;   // 250 MHz

    pkt_framer i_pkt_framer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .count_mode(count_mode),
        .pkt_total(pkt_total), .timed_start(timed_start), .start_time(start_time),
        .narrow(narrow), .pkt_samples(pkt_samples), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .overrun(overrun), .done(done)
    );

    int          checks = 0;
    int          fails  = 0;
    int          wr_cnt = 0;
    int          done_cnt = 0;
    logic [31:0] tsm = '0;          // bench model of sample time
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          finished = 1'b0;

    function automatic logic [15:0] f_i(input logic [31:0] t);
        return {t[7:0] ^ 8'h5A, t[7:0]};
    endfunction
    function automatic logic [15:0] f_q(input logic [31:0] t);
        return {t[7:0] + 8'h21, 8'hC3};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic push_pkt(input bit ovf, input int seq, input bit nar, input int ns,
                            input logic [31:0] t0, input string htag);
        push({ovf, 15'(seq)}, htag);
        push(nar ? 16'(ns) : 16'(2 * ns), "R3 length");
        push(t0[31:16], "R4/R5 ts high");
        push(t0[15:0], "R4 ts low");
        for (int k = 0; k < ns; k++) begin
            logic [31:0] t;
            t = t0 + 32'(k);
            if (nar) push({f_i(t)[15:8], f_q(t)[15:8]}, "R7 packed");
            else begin
                push(f_i(t), "R6 I word");
                push(f_q(t), "R6 Q word");
            end
        end
    endtask

    // spacing in clocks between strobes = gap
    task automatic strobe(input int gap, input bit full_now);
        @(posedge clk); #1;
        smp_valid = 1'b1;
        smp_i     = f_i(tsm);
        smp_q     = f_q(tsm);
        fifo_full = full_now;
        @(posedge clk); #1;
        smp_valid = 1'b0;
        fifo_full = 1'b0;
        tsm       = tsm + 32'd1;
        repeat (gap - 2) @(posedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            if (done) done_cnt++;
            if (fifo_wr) begin
                wr_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected write actual=%0d expected=none", fifo_data);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (fifo_data !== e) begin
                        fails++;
                        $display("FAIL %s actual=%0d expected=%0d", t, fifo_data, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int w0;
        rst_n = 1'b0; enable = 1'b0; count_mode = 1'b0; pkt_total = '0;
        timed_start = 1'b0; start_time = '0; narrow = 1'b0; pkt_samples = '0;
        smp_valid = 1'b0; smp_i = '0; smp_q = '0; fifo_full = 1'b0;
        cycles(3);
        @(negedge clk);
        check(fifo_wr === 1'b0 && done === 1'b0 && overrun === 1'b0, "R1 outputs in reset",
              int'({fifo_wr, done, overrun}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_wr === 1'b0 && done === 1'b0 && overrun === 1'b0, "R1 after reset",
              int'({fifo_wr, done, overrun}), 0);

        // A: wide, two counted packets of three samples
        count_mode = 1'b1; pkt_total = 16'd2; narrow = 1'b0; pkt_samples = 12'd3;
        push_pkt(1'b0, 0, 1'b0, 3, tsm, "R2/R3 header");
        push_pkt(1'b0, 1, 1'b0, 3, tsm + 32'd3, "R8 next header");
        w0 = wr_cnt;
        @(posedge clk); #1; enable = 1'b1;
        cycles(6);
        check(wr_cnt - w0 == 2, "R5 headers before sample", wr_cnt - w0, 2);
        for (int s = 0; s < 6; s++) strobe(8, 1'b0);
        cycles(10);
        check(exp_q.size() == 0, "R8 all words of counted run", exp_q.size(), 0);
        check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
        w0 = wr_cnt;
        for (int s = 0; s < 2; s++) strobe(8, 1'b0);
        cycles(4);
        check(wr_cnt == w0, "R9 no writes after stop", wr_cnt - w0, 0);
        enable = 1'b0;
        cycles(3);

        // B: narrow, two counted packets of four samples
        narrow = 1'b1; pkt_samples = 12'd4;
        push_pkt(1'b0, 0, 1'b1, 4, tsm, "R3 header seq restart");
        push_pkt(1'b0, 1, 1'b1, 4, tsm + 32'd4, "R8 next header");
        @(posedge clk); #1; enable = 1'b1;
        cycles(6);
        for (int s = 0; s < 8; s++) strobe(4, 1'b0);
        cycles(10);
        check(exp_q.size() == 0, "R7 narrow run complete", exp_q.size(), 0);
        check(done_cnt == 2, "R9 done in narrow run", done_cnt, 2);
        enable = 1'b0;
        cycles(3);

        // C: timed start, one wide packet of two samples
        narrow = 1'b0; pkt_samples = 12'd2; pkt_total = 16'd1;
        timed_start = 1'b1; start_time = tsm + 32'd3;
        push_pkt(1'b0, 0, 1'b0, 2, tsm + 32'd3, "R11 header");
        w0 = wr_cnt;
        @(posedge clk); #1; enable = 1'b1;
        cycles(2);
        for (int s = 0; s < 2; s++) strobe(8, 1'b0);
        check(wr_cnt == w0, "R11 nothing before start time", wr_cnt - w0, 0);
        for (int s = 0; s < 3; s++) strobe(8, 1'b0);
        cycles(10);
        check(exp_q.size() == 0, "R11 timed packet complete", exp_q.size(), 0);
        check(done_cnt == 3, "R11 done after timed run", done_cnt, 3);
        enable = 1'b0; timed_start = 1'b0;
        cycles(3);

        // D: continuous, enable dropped during the third packet
        count_mode = 1'b0;
        push_pkt(1'b0, 0, 1'b0, 2, tsm, "R10 header");
        push_pkt(1'b0, 1, 1'b0, 2, tsm + 32'd2, "R8 next header");
        push_pkt(1'b0, 2, 1'b0, 2, tsm + 32'd4, "R10 last header");
        @(posedge clk); #1; enable = 1'b1;
        cycles(6);
        for (int s = 0; s < 5; s++) strobe(8, 1'b0);
        enable = 1'b0;
        for (int s = 0; s < 3; s++) strobe(8, 1'b0);
        cycles(10);
        check(exp_q.size() == 0, "R10 packet closed after enable low", exp_q.size(), 0);
        check(done_cnt == 3, "R10 no done in continuous mode", done_cnt, 3);
        cycles(3);

        // E: overrun at the second strobe of a counted packet
        count_mode = 1'b1; pkt_total = 16'd1; pkt_samples = 12'd3;
        push({1'b0, 15'd0}, "R3 header");
        push(16'd6, "R3 length");
        push(tsm[31:16], "R4 ts high");
        push(tsm[15:0], "R4 ts low");
        push(f_i(tsm), "R6 I word");
        push(f_q(tsm), "R6 Q word");
        push_pkt(1'b1, 1, 1'b0, 3, tsm + 32'd2, "R12 restart header");
        @(posedge clk); #1; enable = 1'b1;
        cycles(6);
        strobe(8, 1'b0);
        strobe(8, 1'b1);
        @(negedge clk);
        check(overrun === 1'b1, "R12 overrun set", int'(overrun), 1);
        for (int s = 0; s < 3; s++) strobe(8, 1'b0);
        cycles(10);
        check(exp_q.size() == 0, "R12 restarted packet complete", exp_q.size(), 0);
        check(done_cnt == 4, "R12 abandoned packet not counted", done_cnt, 4);
        check(overrun === 1'b1, "R12 overrun sticky", int'(overrun), 1);
        enable = 1'b0;
        cycles(3);
        push({1'b0, 15'd0}, "R12 cleared flag in header");
        push(16'd6, "R3 length");
        enable = 1'b1;
        cycles(6);
        check(overrun === 1'b0, "R12 overrun cleared by arm", int'(overrun), 0);
        check(exp_q.size() == 0, "R12 header after re-arm", exp_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule